// File: doc/BRIEF.md
# Interrupt Logical Destination Matcher

This block sits inside a local interrupt controller and decides whether an incoming interprocessor message that is addressed in logical mode belongs to this unit. It keeps two software-visible registers: a format register, whose top nibble picks the addressing model, and a logical destination register, whose top byte holds this unit's logical identity.

Two models are supported. In the flat model, the 8-bit message destination is treated as a bitmask and ANDed with the logical identity. In the cluster model, the upper nibble of the destination names a cluster and must equal the stored cluster number, while the lower nibble is a member mask that must overlap the stored member bits. An all-ones destination acts as a broadcast in both models.

Registers are reached through a plain write port with a combinational read port. A destination arrives with a one-cycle valid strobe, and the accept decision appears as a registered single-cycle flag on the following clock.

Top module: `logdest_matcher`

## Requirements
- R1: After synchronous reset, the format register reads 32'hFFFF_FFFF, the logical destination register reads 32'h0000_0000, and `accept` is 0.
- R2: The format register sits at address 12'h0E0. A write stores `reg_wdata[31:28]` as the model field. Bits 27:0 always read as ones.
- R3: The logical destination register sits at address 12'h0D0. A write stores `reg_wdata[31:24]` as the logical identity. Bits 23:0 always read as zero.
- R4: In the flat model (model field 4'b1111), a strobe is accepted exactly when `dest_id` AND the identity is nonzero.
- R5: In the flat model, `dest_id` 8'hFF is accepted by any nonzero identity and is rejected when the identity is zero.
- R6: In the cluster model (model field 4'b0000), a strobe that is not 8'hFF is accepted exactly when `dest_id[7:4]` equals identity bits 7:4 (register bits 31:28) and `dest_id[3:0]` AND identity bits 3:0 (register bits 27:24) is nonzero.
- R7: In the cluster model, `dest_id` 8'hFF is accepted for every stored cluster number 0 to 15 whenever the member bits are nonzero.
- R8: Any model field value other than 4'b1111 behaves exactly like the cluster model.
- R9: `accept` is 1 for exactly the one cycle after a cycle with `dest_valid` high whose destination matches. It is never 1 after a cycle with `dest_valid` low.
- R10: A register write in the same cycle as a strobe does not affect that strobe's decision. It applies from the next strobe onward.
- R11: A read of any other address returns zero. A write to any other address changes neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write enable |
| reg_addr | input | 12 | Register address for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| dest_valid | input | 1 | Destination strobe |
| dest_id | input | 8 | Logical message destination |
| accept | output | 1 | Registered acceptance flag |

## Verification
`accept` is due exactly one clock edge after the edge that samples the strobe, and register writes take effect on that same edge. Read data is combinational in the cycle the address is presented. The bench drives inputs after a falling edge and then compares `accept` with its reference model at the next falling edge. That reference model is updated in the order the requirements state: decide first using the old register values, then apply the write. Read data is compared at the falling edge of the cycle in which the address is driven.

// File: rtl/ldm_pkg.sv
package ldm_pkg;

    localparam int DEST_W = 8;
    localparam int CL_W   = DEST_W / 2;
    localparam int DATA_W = 32;
    localparam int MODEL_LSB = DATA_W - CL_W;   // model nibble at the top
    localparam int ID_LSB    = DATA_W - DEST_W; // identity byte at the top

    localparam logic [CL_W-1:0] MODEL_FLAT_CODE = '1;

    typedef enum logic {
        MODEL_FLAT    = 1'b0,
        MODEL_CLUSTER = 1'b1
    } model_e;

    typedef struct packed {
        logic [CL_W-1:0] cluster;
        logic [CL_W-1:0] members;
    } lid_t;

    function automatic model_e decode_model(input logic [CL_W-1:0] field);
        return (field == MODEL_FLAT_CODE) ? MODEL_FLAT : MODEL_CLUSTER;
    endfunction

    function automatic logic flat_hit(input lid_t id, input lid_t dest);
        return |(id & dest);
    endfunction

    function automatic logic cluster_hit(input lid_t id, input lid_t dest);
        logic bcast;
        logic same;
        bcast = &dest;
        same  = (dest.cluster == id.cluster);
        return (same | bcast) & (|(dest.members & id.members));
    endfunction

endpackage

// File: rtl/ldm_regs.sv
module ldm_regs
    import ldm_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] FMT_ADDR = 12'h0E0,
    parameter logic [ADDR_W-1:0] LDR_ADDR = 12'h0D0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wen,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output model_e            model,
    output lid_t              lid
);

    logic [CL_W-1:0]   model_q;
    logic [DEST_W-1:0] lid_q;
    logic              unused_wbits;

    assign unused_wbits = ^wdata[ID_LSB-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            model_q <= '1;
            lid_q   <= '0;
        end else if (wen) begin
            if (addr == FMT_ADDR) model_q <= wdata[DATA_W-1:MODEL_LSB];
            if (addr == LDR_ADDR) lid_q   <= wdata[DATA_W-1:ID_LSB];
        end
    end

    always_comb begin
        if (addr == FMT_ADDR)      rdata = {model_q, {MODEL_LSB{1'b1}}};
        else if (addr == LDR_ADDR) rdata = {lid_q, {ID_LSB{1'b0}}};
        else                       rdata = '0;
    end

    assign model = decode_model(model_q);
    assign lid   = lid_t'(lid_q);

    // R2 / R3: reserved fields keep fixed values at the read port
    a_r2_fmt_reserved_ones: assert property (@(posedge clk) disable iff (rst)
        (addr == FMT_ADDR) |-> (rdata[MODEL_LSB-1:0] == {MODEL_LSB{1'b1}}));
    a_r3_ldr_low_zero: assert property (@(posedge clk) disable iff (rst)
        (addr == LDR_ADDR) |-> (rdata[ID_LSB-1:0] == '0));

endmodule

// File: rtl/ldm_match.sv
module ldm_match
    import ldm_pkg::*;
(
    input  model_e model,
    input  lid_t   lid,
    input  lid_t   dest,
    output logic   hit
);

    logic [1:0] hit_by_model;

    for (genvar m = 0; m < 2; m++) begin : g_model
        if (m == int'(MODEL_FLAT)) begin : g_flat
            assign hit_by_model[m] = flat_hit(lid, dest);
        end else begin : g_cluster
            assign hit_by_model[m] = cluster_hit(lid, dest);
        end
    end

    assign hit = hit_by_model[model];

endmodule

// File: rtl/logdest_matcher.sv
module logdest_matcher
    import ldm_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] FMT_ADDR = 12'h0E0,
    parameter logic [ADDR_W-1:0] LDR_ADDR = 12'h0D0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              dest_valid,
    input  logic [7:0]        dest_id,
    output logic              accept
);

    model_e model;
    lid_t   lid;
    logic   hit;
    logic   accept_q;

    ldm_regs #(.ADDR_W(ADDR_W), .FMT_ADDR(FMT_ADDR), .LDR_ADDR(LDR_ADDR)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wen   (reg_wen),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .model (model),
        .lid   (lid)
    );

    ldm_match u_match (
        .model (model),
        .lid   (lid),
        .dest  (lid_t'(dest_id)),
        .hit   (hit)
    );

    // Decision uses register values from before any same-cycle write (R10)
    always_ff @(posedge clk) begin
        if (rst) accept_q <= 1'b0;
        else     accept_q <= dest_valid & hit;
    end

    assign accept = accept_q;

    // R9: no accept without a strobe in the previous cycle
    a_r9_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        accept |-> $past(dest_valid));

    // R5: flat broadcast reaches any nonzero identity
    a_r5_flat_bcast: assert property (@(posedge clk) disable iff (rst)
        ($past(dest_valid) && $past(dest_id) == 8'hFF &&
         $past(model) == MODEL_FLAT && $past(lid) != '0) |-> accept);

    // R6: wrong cluster never accepts unless broadcast
    a_r6_cluster_miss: assert property (@(posedge clk) disable iff (rst)
        ($past(dest_valid) && $past(model) == MODEL_CLUSTER &&
         $past(dest_id) != 8'hFF &&
         $past(dest_id[7:4]) != $past(lid.cluster)) |-> !accept);

    // R4: flat model with no common bit never accepts
    a_r4_flat_disjoint: assert property (@(posedge clk) disable iff (rst)
        ($past(dest_valid) && $past(model) == MODEL_FLAT &&
         ($past(dest_id) & $past(lid)) == '0) |-> !accept);

endmodule

// File: tb/test_logdest_matcher.sv
`timescale 1ns/1ps
module test_logdest_matcher;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wen = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dest_valid = 1'b0;
    logic [7:0]  dest_id = '0;
    logic        accept;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench-side view of the registers
    logic [3:0] m_model = 4'hF;
    logic [7:0] m_id    = 8'h00;

    localparam logic [11:0] A_FMT = 12'h0E0;
    localparam logic [11:0] A_LDR = 12'h0D0;

    always #4 clk = ~clk;

    logdest_matcher i_logdest_matcher (
        .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dest_valid(dest_valid),
        .dest_id(dest_id), .accept(accept)
    );

    function automatic bit ref_accept(input logic [3:0] mdl, input logic [7:0] id,
                                      input logic [7:0] d);
        int common = 0;
        if (mdl == 4'hF) begin
            for (int b = 0; b < 8; b++) if (id[b] && d[b]) common++;
            return common > 0;
        end
        for (int b = 0; b < 4; b++) if (id[b] && d[b]) common++;
        if (common == 0) return 1'b0;
        if (d == 8'hFF) return 1'b1;
        return d[7:4] == id[7:4];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock: drive, predict, advance, compare accept
    task automatic cyc(input string req, input bit wen, input logic [11:0] a,
                       input logic [31:0] wd, input bit v, input logic [7:0] d);
        bit exp;
        reg_wen = wen; reg_addr = a; reg_wdata = wd; dest_valid = v; dest_id = d;
        exp = v && ref_accept(m_model, m_id, d);
        if (wen && a == A_FMT) m_model = wd[31:28];
        if (wen && a == A_LDR) m_id = wd[31:24];
        @(posedge clk);
        @(negedge clk);
        reg_wen = 1'b0; dest_valid = 1'b0;
        check(req, {31'b0, accept}, {31'b0, exp});
    endtask

    task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic wr(input string req, input logic [11:0] a, input logic [31:0] wd);
        cyc(req, 1'b1, a, wd, 1'b0, 8'h00);
    endtask

    task automatic strobe(input string req, input logic [7:0] d);
        cyc(req, 1'b0, 12'h000, 32'h0, 1'b1, d);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 accept", {31'b0, accept}, 32'h0);
        rd("R1 fmt", A_FMT, 32'hFFFF_FFFF);
        rd("R1 ldr", A_LDR, 32'h0);

        // R5 flat broadcast with zero identity
        strobe("R5 zero id", 8'hFF);

        // R3 identity write and reserved zeros
        wr("R3", A_LDR, 32'hA5FF_FFFF);
        rd("R3 ldr", A_LDR, 32'hA500_0000);

        // R4 flat patterns
        for (int i = 0; i < 8; i++) strobe("R4 single bit", 8'h01 << i);
        strobe("R4 disjoint", 8'h5A);
        strobe("R5 bcast", 8'hFF);
        wr("R4", A_LDR, 32'h1000_0000);
        strobe("R4 hit", 8'h30);
        strobe("R4 miss", 8'hEF);

        // R9 idle cycles and back-to-back strobes
        for (int i = 0; i < 3; i++) cyc("R9 idle", 1'b0, 12'h000, 0, 1'b0, 8'hFF);
        strobe("R9 b2b", 8'h10);
        strobe("R9 b2b", 8'h10);
        cyc("R9 after", 1'b0, 12'h000, 0, 1'b0, 8'h10);

        // R2 format writes
        wr("R2", A_FMT, 32'h0000_0000);
        rd("R2 fmt", A_FMT, 32'h0FFF_FFFF);

        // R6 cluster patterns: cluster 3, members 0101
        wr("R6", A_LDR, 32'h3500_0000);
        strobe("R6 hit", 8'h31);
        strobe("R6 hit2", 8'h34);
        strobe("R6 member miss", 8'h3A);
        strobe("R6 cluster miss", 8'h21);
        strobe("R6 cluster miss", 8'hF5);
        strobe("R7 bcast", 8'hFF);

        // R7 broadcast over every cluster, with and without members
        for (int c = 0; c < 16; c++) begin
            wr("R7", A_LDR, {c[3:0], 4'h8, 24'h0});
            strobe("R7 bcast", 8'hFF);
        end
        wr("R7", A_LDR, 32'h4000_0000);
        strobe("R7 no members", 8'hFF);

        // R8 odd model values act as cluster
        wr("R8", A_FMT, 32'h5123_4567);
        rd("R8 fmt", A_FMT, 32'h5FFF_FFFF);
        wr("R8", A_LDR, 32'h6200_0000);
        strobe("R8 cluster hit", 8'h62);
        strobe("R8 flat would hit", 8'h22);
        wr("R8", A_FMT, 32'hE000_0000);
        strobe("R8 E model", 8'h13);
        strobe("R8 E model hit", 8'h66);

        // R10 same-cycle write and strobe
        wr("R10", A_FMT, 32'hF000_0000);
        wr("R10", A_LDR, 32'h0100_0000);
        cyc("R10 old id", 1'b1, A_LDR, 32'h0200_0000, 1'b1, 8'h02);
        strobe("R10 new id", 8'h02);
        cyc("R10 old model", 1'b1, A_FMT, 32'h0000_0000, 1'b1, 8'h03);
        strobe("R10 new model", 8'h03);

        // R11 other addresses
        wr("R11", 12'h0E4, 32'h0000_0000);
        wr("R11", 12'h0D4, 32'hFF00_0000);
        rd("R11 other", 12'h0E4, 32'h0);
        rd("R11 fmt kept", A_FMT, 32'h0FFF_FFFF);
        rd("R11 ldr kept", A_LDR, 32'h0200_0000);
        strobe("R11 behaviour kept", 8'h02);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule